// File: doc/BRIEF.md
# Tunnel Packet Header Parser

This block sits inline in a 128-bit packet stream of the data plane. Packets start with an Ethernet header and usually carry IPv4 and UDP. While the packet flows through, the block reads the first three bus beats of each packet. From them it extracts the IPv4 source and destination addresses, the IP protocol and both UDP ports. When the packet is addressed to the tunnel service, it also extracts the tunnel message type and a peer index. It presents these fields as a metadata record beside the stream, so that later stages can steer the packet without parsing it again.

The data path is a pure pass-through. Every beat leaves in the same cycle it arrives, with its data, byte enables and end marker untouched. Back-pressure from downstream reaches upstream directly: the stream interface follows valid/ready rules. A beat is transferred only in a cycle where valid and ready are both high. The sender must hold valid and the beat contents steady until that cycle. The ready signal may drop at any time, and while it is low the header capture pauses along with the stream.

On the bus, byte k of a packet sits on lane k mod 16 of beat k/16, at bits [8*lane+7 : 8*lane], so the lanes are little-endian. The Ethernet, IPv4 and UDP fields are in network order, and the parser reassembles them most significant byte first. The tunnel fields are little-endian and are taken in bus order. The tunnel service port is a plain configuration input, compared against both UDP ports. This lets locally generated tunnel traffic and received tunnel traffic both be recognised.

Top module: `tunnel_hdr_parser`

## Requirements
- R1: The output stream equals the input stream in the same cycle: m_tvalid, m_tdata, m_tkeep and m_tlast copy s_tvalid, s_tdata, s_tkeep and s_tlast, and s_tready copies m_tready.
- R2: Header beats are counted only on transfer cycles (valid and ready both high). The count restarts at the beat after a transfer with the end marker, so back-to-back packets and stalls do not disturb it.
- R3: Network-order fields are taken most significant byte first. The protocol is byte 23. The source address is bytes 26..29 and the destination address is bytes 30..33, with byte 26 and byte 30 as the MSBs. The source port is bytes 34..35 and the destination port is bytes 36..37, with the lower offset as MSB.
- R4: Tunnel fields are little-endian. The message type is byte 42. The 16-bit peer index is bytes 46 (LSB) and 47 (MSB). Both lie inside the third beat.
- R5: A packet is a tunnel message only when all of the following hold: bytes 12..13 equal 0x0800, byte 14 equals 0x45, the protocol equals 17, and the source port or the destination port equals cfg_listen_port.
- R6: For a packet that is not a tunnel message, meta_is_tunnel is 0 and both meta_msg_type and meta_peer_idx read 0. The address, protocol and port fields are still reported.
- R7: If a packet has at least three beats, meta_valid goes high in the cycle after its third beat is transferred. It stays high with unchanged fields through the cycle in which the end-marker beat is transferred, and is low in the following cycle.
- R8: If a packet ends in its first or second beat, meta_valid goes high in the cycle after that last beat, with meta_truncated at 1 and meta_is_tunnel at 0. Any field whose bytes lie in beats that were never received reads 0.
- R9: Metadata of a packet of one to three beats stays valid and unchanged until the next beat transfer. That transfer either clears it or replaces it with the next record.
- R10: The block accepts one beat per cycle with no dead cycles between packets, so a packet of N beats passes in N cycles under continuous ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_listen_port | input | 16 | UDP port of the tunnel service |
| s_tvalid | input | 1 | Upstream beat valid |
| s_tready | output | 1 | Upstream ready, copy of m_tready |
| s_tdata | input | 128 | Upstream beat data |
| s_tkeep | input | 16 | Upstream byte enables |
| s_tlast | input | 1 | Upstream end-of-packet marker |
| m_tvalid | output | 1 | Downstream beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 128 | Downstream beat data |
| m_tkeep | output | 16 | Downstream byte enables |
| m_tlast | output | 1 | Downstream end-of-packet marker |
| meta_valid | output | 1 | Metadata record valid |
| meta_src_ip | output | 32 | IPv4 source address |
| meta_dst_ip | output | 32 | IPv4 destination address |
| meta_ip_proto | output | 8 | IP protocol number |
| meta_src_port | output | 16 | UDP source port |
| meta_dst_port | output | 16 | UDP destination port |
| meta_msg_type | output | 8 | Tunnel message type, 0 when not a tunnel message |
| meta_peer_idx | output | 16 | Tunnel peer index, 0 when not a tunnel message |
| meta_is_tunnel | output | 1 | Packet classified as a tunnel message |
| meta_truncated | output | 1 | Packet ended before its third beat |

## Verification
The in-line properties assume a well-behaved upstream. Once valid is raised it stays high with the same beat until ready accepts it. The end marker appears only on a beat that is actually transferred. cfg_listen_port changes only while no packet is in flight. The bench's driver keeps to these rules: it holds each beat until it observes the handshake, inserts idle gaps only between beats it has not yet presented, and changes the listen port only after the packets already queued have drained. The downstream ready is toggled pseudo-randomly in some runs, so the stall paths of the header capture are exercised too.

// File: rtl/thp_pkg.sv
package thp_pkg;

  localparam int unsigned BUS_W   = 128;
  localparam int unsigned LANES   = BUS_W / 8;
  localparam int unsigned PEER_W  = 16;
  localparam int unsigned BEAT_CW = 2;

  // header byte offsets from the start of the frame
  localparam int unsigned OFF_ETYPE = 12;
  localparam int unsigned OFF_VIHL  = 14;
  localparam int unsigned OFF_PROTO = 23;
  localparam int unsigned OFF_SIP   = 26;
  localparam int unsigned OFF_DIP   = 30;
  localparam int unsigned OFF_SPORT = 34;
  localparam int unsigned OFF_DPORT = 36;
  localparam int unsigned OFF_MTYPE = 42;
  localparam int unsigned OFF_PEER  = 46;

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  VIHL_PLAIN = 8'h45;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef struct packed {
    logic [31:0]       src_ip;
    logic [31:0]       dst_ip;
    logic [7:0]        proto;
    logic [15:0]       src_port;
    logic [15:0]       dst_port;
    logic [7:0]        msg_type;
    logic [PEER_W-1:0] peer_idx;
    logic              is_tunnel;
    logic              truncated;
  } hdr_meta_t;

  function automatic logic [7:0] lane_byte(input logic [BUS_W-1:0] d,
                                           input int unsigned off);
    return d[8*(off % LANES) +: 8];
  endfunction

  // network order: lower offset is the high byte
  function automatic logic [15:0] net16(input logic [BUS_W-1:0] d,
                                        input int unsigned off);
    return {lane_byte(d, off), lane_byte(d, off + 1)};
  endfunction

  // bus order: lower offset is the low byte
  function automatic logic [15:0] bus16(input logic [BUS_W-1:0] d,
                                        input int unsigned off);
    return {lane_byte(d, off + 1), lane_byte(d, off)};
  endfunction

endpackage

// File: rtl/thp_beat_tracker.sv
module thp_beat_tracker
  import thp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer,
  input  logic               last,
  output logic [BEAT_CW-1:0] idx,
  output logic               capture,
  output logic               first
);

  localparam logic [BEAT_CW-1:0] HDR_LAST = BEAT_CW'(2);
  localparam logic [BEAT_CW-1:0] SAT      = {BEAT_CW{1'b1}};

  logic [BEAT_CW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          idx_q <= '0;
    else if (xfer) begin
      if (last)          idx_q <= '0;
      else if (idx_q != SAT) idx_q <= idx_q + 1'b1;
    end
  end

  assign idx     = idx_q;
  assign first   = (idx_q == '0);
  assign capture = xfer && ((idx_q == HDR_LAST) || (last && (idx_q < HDR_LAST)));

  assert_count_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && last) |=> (idx == '0));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(idx));

endmodule

// File: rtl/thp_field_stage.sv
module thp_field_stage
  import thp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer,
  input  logic [BEAT_CW-1:0] idx,
  input  logic [BUS_W-1:0]   data,
  output logic [15:0]        sh_etype,
  output logic [7:0]         sh_vihl,
  output logic [7:0]         sh_proto,
  output logic [31:0]        sh_sip,
  output logic [15:0]        sh_dip_hi
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_etype  <= '0;
      sh_vihl   <= '0;
      sh_proto  <= '0;
      sh_sip    <= '0;
      sh_dip_hi <= '0;
    end else if (xfer) begin
      if (idx == BEAT_CW'(0)) begin
        sh_etype <= net16(data, OFF_ETYPE);
        sh_vihl  <= lane_byte(data, OFF_VIHL);
      end
      if (idx == BEAT_CW'(1)) begin
        sh_proto  <= lane_byte(data, OFF_PROTO);
        sh_sip    <= {net16(data, OFF_SIP), net16(data, OFF_SIP + 2)};
        sh_dip_hi <= net16(data, OFF_DIP);
      end
    end
  end

  assert_shadow_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer || idx > BEAT_CW'(1)) |=> ($stable(sh_sip) && $stable(sh_etype)));

endmodule

// File: rtl/thp_meta_gen.sv
module thp_meta_gen
  import thp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer,
  input  logic               last,
  input  logic [BEAT_CW-1:0] idx,
  input  logic               capture,
  input  logic               first,
  input  logic [BUS_W-1:0]   data,
  input  logic [15:0]        listen_port,
  input  logic [15:0]        sh_etype,
  input  logic [7:0]         sh_vihl,
  input  logic [7:0]         sh_proto,
  input  logic [31:0]        sh_sip,
  input  logic [15:0]        sh_dip_hi,
  output hdr_meta_t          meta,
  output logic               meta_valid
);

  hdr_meta_t   nxt;
  logic [15:0] etype, dip_hi, dip_lo;
  logic [7:0]  vihl, mtype;
  logic [PEER_W-1:0] peer;
  logic        trunc, tun;

  always_comb begin
    nxt    = '0;
    etype  = (idx == BEAT_CW'(0)) ? net16(data, OFF_ETYPE) : sh_etype;
    vihl   = (idx == BEAT_CW'(0)) ? lane_byte(data, OFF_VIHL) : sh_vihl;
    dip_hi = '0;
    dip_lo = '0;
    mtype  = '0;
    peer   = '0;
    trunc  = (idx < BEAT_CW'(2));
    if (idx == BEAT_CW'(1)) begin
      nxt.proto  = lane_byte(data, OFF_PROTO);
      nxt.src_ip = {net16(data, OFF_SIP), net16(data, OFF_SIP + 2)};
      dip_hi     = net16(data, OFF_DIP);
    end else if (idx == BEAT_CW'(2)) begin
      nxt.proto     = sh_proto;
      nxt.src_ip    = sh_sip;
      dip_hi        = sh_dip_hi;
      dip_lo        = net16(data, OFF_DIP + 2);
      nxt.src_port  = net16(data, OFF_SPORT);
      nxt.dst_port  = net16(data, OFF_DPORT);
      mtype         = lane_byte(data, OFF_MTYPE);
      peer          = PEER_W'(bus16(data, OFF_PEER));
    end
    nxt.dst_ip = {dip_hi, dip_lo};
    tun = !trunc && (etype == ETYPE_IPV4) && (vihl == VIHL_PLAIN) &&
          (nxt.proto == PROTO_UDP) &&
          ((nxt.src_port == listen_port) || (nxt.dst_port == listen_port));
    nxt.is_tunnel = tun;
    nxt.truncated = trunc;
    nxt.msg_type  = tun ? mtype : '0;
    nxt.peer_idx  = tun ? peer  : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta       <= '0;
      meta_valid <= 1'b0;
    end else if (capture) begin
      meta       <= nxt;
      meta_valid <= 1'b1;
    end else if (xfer && (last || first)) begin
      meta_valid <= 1'b0;
    end
  end

  logic unused_data;
  assign unused_data = ^data;

  assert_nontunnel_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_valid && !meta.is_tunnel) |-> (meta.msg_type == '0 && meta.peer_idx == '0));
  assert_trunc_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_valid && meta.truncated) |-> !meta.is_tunnel);
  assert_meta_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_valid && !xfer) |=> (meta_valid && $stable(meta)));
  assert_meta_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meta_valid) |-> $past(xfer));

endmodule

// File: rtl/tunnel_hdr_parser.sv
module tunnel_hdr_parser
  import thp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cfg_listen_port,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic [BUS_W-1:0] s_tdata,
  input  logic [LANES-1:0] s_tkeep,
  input  logic             s_tlast,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [BUS_W-1:0] m_tdata,
  output logic [LANES-1:0] m_tkeep,
  output logic             m_tlast,
  output logic             meta_valid,
  output logic [31:0]      meta_src_ip,
  output logic [31:0]      meta_dst_ip,
  output logic [7:0]       meta_ip_proto,
  output logic [15:0]      meta_src_port,
  output logic [15:0]      meta_dst_port,
  output logic [7:0]       meta_msg_type,
  output logic [PEER_W-1:0] meta_peer_idx,
  output logic             meta_is_tunnel,
  output logic             meta_truncated
);

  logic               xfer, capture, first;
  logic [BEAT_CW-1:0] idx;
  logic [15:0]        sh_etype, sh_dip_hi;
  logic [7:0]         sh_vihl, sh_proto;
  logic [31:0]        sh_sip;
  hdr_meta_t          meta;

  assign m_tvalid = s_tvalid;
  assign m_tdata  = s_tdata;
  assign m_tkeep  = s_tkeep;
  assign m_tlast  = s_tlast;
  assign s_tready = m_tready;
  assign xfer     = s_tvalid && m_tready;

  thp_beat_tracker u_beats (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .last(s_tlast),
    .idx(idx), .capture(capture), .first(first)
  );

  thp_field_stage u_fields (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .idx(idx), .data(s_tdata),
    .sh_etype(sh_etype), .sh_vihl(sh_vihl), .sh_proto(sh_proto),
    .sh_sip(sh_sip), .sh_dip_hi(sh_dip_hi)
  );

  thp_meta_gen u_meta (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .last(s_tlast), .idx(idx),
    .capture(capture), .first(first), .data(s_tdata),
    .listen_port(cfg_listen_port),
    .sh_etype(sh_etype), .sh_vihl(sh_vihl), .sh_proto(sh_proto),
    .sh_sip(sh_sip), .sh_dip_hi(sh_dip_hi),
    .meta(meta), .meta_valid(meta_valid)
  );

  assign meta_src_ip    = meta.src_ip;
  assign meta_dst_ip    = meta.dst_ip;
  assign meta_ip_proto  = meta.proto;
  assign meta_src_port  = meta.src_port;
  assign meta_dst_port  = meta.dst_port;
  assign meta_msg_type  = meta.msg_type;
  assign meta_peer_idx  = meta.peer_idx;
  assign meta_is_tunnel = meta.is_tunnel;
  assign meta_truncated = meta.truncated;

  assert_valid_after_xfer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> m_tvalid);

endmodule

// File: tb/test_tunnel_hdr_parser.sv
`timescale 1ns/100ps
module test_tunnel_hdr_parser;

  typedef struct packed {
    logic [31:0] sip;
    logic [31:0] dip;
    logic [7:0]  proto;
    logic [15:0] sp;
    logic [15:0] dp;
    logic [7:0]  mtype;
    logic [15:0] peer;
    logic        tun;
    logic        trunc;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  cfg_listen_port = 16'd51820;
  logic         s_tvalid = 1'b0;
  logic         s_tready;
  logic [127:0] s_tdata = '0;
  logic [15:0]  s_tkeep = '0;
  logic         s_tlast = 1'b0;
  logic         m_tvalid;
  logic         m_tready = 1'b1;
  logic [127:0] m_tdata;
  logic [15:0]  m_tkeep;
  logic         m_tlast;
  logic         meta_valid;
  logic [31:0]  meta_src_ip, meta_dst_ip;
  logic [7:0]   meta_ip_proto, meta_msg_type;
  logic [15:0]  meta_src_port, meta_dst_port, meta_peer_idx;
  logic         meta_is_tunnel, meta_truncated;

  always #2 clk = ~clk;

  tunnel_hdr_parser i_tunnel_hdr_parser (
    .clk(clk), .rst_n(rst_n), .cfg_listen_port(cfg_listen_port),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .meta_valid(meta_valid), .meta_src_ip(meta_src_ip), .meta_dst_ip(meta_dst_ip),
    .meta_ip_proto(meta_ip_proto), .meta_src_port(meta_src_port),
    .meta_dst_port(meta_dst_port), .meta_msg_type(meta_msg_type),
    .meta_peer_idx(meta_peer_idx), .meta_is_tunnel(meta_is_tunnel),
    .meta_truncated(meta_truncated)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  bit    monitor_on = 1'b0;
  bit    rand_ready = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  cur_exp;
  string cur_tag = "R7";
  bit    exp_valid = 1'b0;
  int    out_idx = 0;
  logic [7:0] pkt [0:127];

  // ready generator: changes only just after a rising edge
  always @(posedge clk) begin
    #1;
    if (rand_ready) m_tready <= ($urandom % 4) != 0;
    else            m_tready <= 1'b1;
  end

  function automatic exp_t live_meta();
    exp_t e;
    e.sip = meta_src_ip; e.dip = meta_dst_ip; e.proto = meta_ip_proto;
    e.sp = meta_src_port; e.dp = meta_dst_port; e.mtype = meta_msg_type;
    e.peer = meta_peer_idx; e.tun = meta_is_tunnel; e.trunc = meta_truncated;
    return e;
  endfunction

  // monitor: compares at falling edges, then models the upcoming transfer
  always @(negedge clk) begin
    if (monitor_on) begin
      n_vec++;
      if ({m_tvalid, m_tdata, m_tkeep, m_tlast, s_tready} !==
          {s_tvalid, s_tdata, s_tkeep, s_tlast, m_tready}) begin
        n_bad++;
        $display("FAIL R1 passthrough: out=%0h/%0b ready_up=%0b exp=%0h/%0b ready_dn=%0b",
                 m_tdata, m_tvalid, s_tready, s_tdata, s_tvalid, m_tready);
      end
      n_vec++;
      if (meta_valid !== exp_valid) begin
        n_bad++;
        $display("FAIL R7/R9 meta_valid: actual=%0b expected=%0b", meta_valid, exp_valid);
      end else if (exp_valid && live_meta() !== cur_exp) begin
        n_bad++;
        $display("FAIL %s meta: actual=%h expected=%h", cur_tag, live_meta(), cur_exp);
      end
      if (m_tvalid && m_tready) begin
        if (out_idx == 2 || (m_tlast && out_idx < 2)) begin
          if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R2 unexpected capture: actual=capture expected=none");
          end else begin
            cur_exp = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            exp_valid = 1'b1;
          end
        end else if (m_tlast || out_idx == 0) begin
          exp_valid = 1'b0;
        end
        if (m_tlast)          out_idx = 0;
        else if (out_idx < 3) out_idx++;
      end
    end
  end

  task automatic build_and_send(input int nbeats, input logic [15:0] etype,
      input logic [7:0] vihl, input logic [7:0] proto, input logic [31:0] sip,
      input logic [31:0] dip, input logic [15:0] sp, input logic [15:0] dp,
      input logic [7:0] mtype, input logic [15:0] peer, input int gaps,
      input string tag);
    exp_t e;
    bit   ok;
    for (int k = 0; k < 128; k++) pkt[k] = 8'(k * 37 + nbeats);
    pkt[12] = etype[15:8]; pkt[13] = etype[7:0];
    pkt[14] = vihl; pkt[23] = proto;
    pkt[26] = sip[31:24]; pkt[27] = sip[23:16]; pkt[28] = sip[15:8]; pkt[29] = sip[7:0];
    pkt[30] = dip[31:24]; pkt[31] = dip[23:16]; pkt[32] = dip[15:8]; pkt[33] = dip[7:0];
    pkt[34] = sp[15:8]; pkt[35] = sp[7:0];
    pkt[36] = dp[15:8]; pkt[37] = dp[7:0];
    pkt[42] = mtype; pkt[46] = peer[7:0]; pkt[47] = peer[15:8];
    e = '0;
    if (nbeats >= 2) begin
      e.sip = sip; e.proto = proto; e.dip = {dip[31:16], 16'h0};
    end
    if (nbeats >= 3) begin
      e.dip = dip; e.sp = sp; e.dp = dp;
      e.tun = (etype == 16'h0800) && (vihl == 8'h45) && (proto == 8'd17) &&
              (sp == cfg_listen_port || dp == cfg_listen_port);
      e.mtype = e.tun ? mtype : 8'h0;
      e.peer  = e.tun ? peer  : 16'h0;
    end else begin
      e.trunc = 1'b1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int b = 0; b < nbeats; b++) begin
      if (gaps != 0 && (b % 2) == 1) begin
        s_tvalid = 1'b0;
        @(posedge clk); #1;
      end
      for (int l = 0; l < 16; l++) s_tdata[8*l +: 8] = pkt[16*b + l];
      s_tkeep  = '1;
      s_tlast  = (b == nbeats - 1);
      s_tvalid = 1'b1;
      do begin
        @(negedge clk);
        ok = s_tready;
        @(posedge clk); #1;
      end while (!ok);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) begin @(posedge clk); #1; end
  endtask

  task automatic check(input bit cond, input string msg, input int act, input int expv);
    n_vec++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  initial begin
    int t0;
    repeat (3) @(posedge clk);
    #1;
    check(meta_valid == 1'b0, "R7 reset meta_valid", meta_valid, 0);
    check(m_tvalid == 1'b0, "R1 reset m_tvalid", m_tvalid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    monitor_on = 1'b1;

    // R3 R4 R5: transport data message, matching destination port
    build_and_send(5, 16'h0800, 8'h45, 8'd17, 32'h0A090001, 32'h0A090002,
                   16'd40000, 16'd51820, 8'd4, 16'hBEEF, 0, "R3/R4/R5");
    // R10: back-to-back packets, one beat per cycle
    t0 = $time;
    build_and_send(4, 16'h0800, 8'h45, 8'd17, 32'hC0A80101, 32'h0A0A0001,
                   16'd51820, 16'd51820, 8'd1, 16'h1234, 0, "R5");
    check(($time - t0) == 4 * 4, "R10 beat rate (ns)", $time - t0, 16);
    // R5: source port match, with gaps
    build_and_send(6, 16'h0800, 8'h45, 8'd17, 32'h01020304, 32'h05060708,
                   16'd51820, 16'd53, 8'd2, 16'h00A5, 1, "R5");
    // R6: wrong port, TCP, IPv6, options present
    build_and_send(4, 16'h0800, 8'h45, 8'd17, 32'h11111111, 32'h22222222,
                   16'd1000, 16'd2000, 8'd4, 16'h7777, 0, "R6 port");
    build_and_send(4, 16'h0800, 8'h45, 8'd6, 32'h33333333, 32'h44444444,
                   16'd51820, 16'd51820, 8'd4, 16'h7777, 0, "R6 proto");
    build_and_send(4, 16'h86DD, 8'h45, 8'd17, 32'h55555555, 32'h66666666,
                   16'd51820, 16'd51820, 8'd4, 16'h7777, 0, "R6 ethertype");
    build_and_send(4, 16'h0800, 8'h46, 8'd17, 32'h77777777, 32'h88888888,
                   16'd51820, 16'd51820, 8'd4, 16'h7777, 0, "R6 ihl");
    drain();
    // R8 R9: short packets back to back
    build_and_send(3, 16'h0800, 8'h45, 8'd17, 32'hAABBCCDD, 32'h01234567,
                   16'd7, 16'd51820, 8'd3, 16'h4321, 0, "R9 three-beat");
    build_and_send(2, 16'h0800, 8'h45, 8'd17, 32'hDEADBEEF, 32'hFEEDF00D,
                   16'd51820, 16'd51820, 8'd4, 16'h1111, 0, "R8 two-beat");
    build_and_send(1, 16'h0800, 8'h45, 8'd17, 32'h12345678, 32'h9ABCDEF0,
                   16'd51820, 16'd51820, 8'd4, 16'h2222, 0, "R8 one-beat");
    build_and_send(1, 16'h0800, 8'h45, 8'd17, 32'h0, 32'h0,
                   16'd0, 16'd0, 8'd0, 16'h0, 0, "R8 one-beat again");
    drain();
    // R2: random back-pressure over mixed lengths
    rand_ready = 1'b1;
    for (int p = 0; p < 24; p++) begin
      build_and_send(1 + (p % 7), 16'h0800, 8'h45, 8'd17, 32'(p * 7919),
                     32'(p * 104729), (p % 3 == 0) ? 16'd51820 : 16'(p),
                     (p % 3 == 1) ? 16'd51820 : 16'(p + 9), 8'(p), 16'(p * 31),
                     p % 2, "R2");
    end
    drain();
    rand_ready = 1'b0;
    drain();
    // R5: listen port changed between packets
    cfg_listen_port = 16'd4500;
    build_and_send(4, 16'h0800, 8'h45, 8'd17, 32'h0A000001, 32'h0A000002,
                   16'd9, 16'd4500, 8'd4, 16'hCAFE, 0, "R5 new port");
    build_and_send(4, 16'h0800, 8'h45, 8'd17, 32'h0A000003, 32'h0A000004,
                   16'd9, 16'd51820, 8'd4, 16'hCAFE, 0, "R5 old port");
    drain();
    check(exp_q.size() == 0, "R7 records left unconsumed", exp_q.size(), 0);
    check(meta_valid == 1'b0, "R7 idle meta_valid", meta_valid, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule